// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This block computes the difference x - y of two 32-bit binary floating-point operands in the common single-precision layout: sign in bit 31, an 8-bit biased exponent in bits 30:23, and a 23-bit fraction in bits 22:0. Each operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. NaN, infinity and zero pairs are settled by a fixed priority table. All other pairs go to an arithmetic path. That path inverts the sign of y and adds, with three extra low bits for guard, round and sticky. It normalizes the sum and rounds it under a 2-bit rounding-mode input.

The operands are presented together with a strobe. The result and four exception flags (invalid, overflow, underflow, inexact) are registered and appear one clock later with their own strobe. Between strobes the registered outputs hold their last value. Subnormal operands are accepted as they are and are not flushed to zero.

Top module: `fp32_subtractor`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `op_valid` high. `diff_out` and the flags update only on such strobes and otherwise keep their value. After reset, all outputs are 0.
- R2: If x is a signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is x with bit 22 set, and invalid is raised. This holds whatever y is. Otherwise, if y is a signaling NaN, the result is y with bit 22 set, and invalid is raised.
- R3: A quiet NaN (bit 22 set) passes through unchanged and raises no flag. If both operands are quiet NaNs, x is returned. If neither operand is a signaling NaN and only y is a quiet NaN, y is returned.
- R4: Infinity minus infinity of the same sign returns 0x7FC00000 and raises invalid. If the signs differ, x is returned.
- R5: A finite or zero x minus an infinite y returns infinity with the sign opposite to y's. An infinite x minus a finite or zero y returns x. Neither case raises a flag.
- R6: Zero minus zero returns x when the signs differ. When the signs are equal, it returns +0, or -0 under mode 3. Zero minus a nonzero finite y returns y with bit 31 inverted. A nonzero finite x minus zero returns x.
- R7: The finite result is correctly rounded under `rnd_mode`. The encoding is 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. Inexact is raised exactly when a nonzero bit is discarded.
- R8: A difference of two equal nonzero values is exact zero. It is -0 under mode 3 and +0 under the other modes, and it raises no flag.
- R9: A rounded exponent of 255 or more raises overflow and inexact. The result is infinity under mode 0, under mode 2 for a positive sign and under mode 3 for a negative sign. Otherwise it is the largest finite magnitude (0x7F7FFFFF with the result sign).
- R10: Subnormal operands are used at full precision, and results below the normal range come out as subnormals. Underflow is raised only for a result that is tiny before rounding and also inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operand strobe |
| op_x | input | 32 | Minuend |
| op_y | input | 32 | Subtrahend |
| rnd_mode | input | 2 | Rounding mode (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf) |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| diff_out | output | 32 | Registered difference |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Overflow |
| flag_underflow | output | 1 | Underflow |
| flag_inexact | output | 1 | Inexact |

## Verification
All arithmetic and special-case logic sits between the input ports and a single output register, so every result and flag is due one rising edge after the edge that captures `op_valid`. The bench drives each operand set on a falling edge and pulses the strobe for one cycle. It then samples `res_valid`, `diff_out` and the flags on the next falling edge, which lies half a period after the capturing edge. It also checks over idle cycles that the strobe drops and the registered values stay put.

// File: rtl/fpsub_pkg.sv
// Shared definitions for the single-precision subtractor.
// Assumes the standard 1/8/23 binary layout as the default geometry.
package fpsub_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;

    // Operand classes produced by the classifier
    typedef enum logic [2:0] {
        CL_ZERO  = 3'd0,
        CL_SUB   = 3'd1,
        CL_NORM  = 3'd2,
        CL_INF   = 3'd3,
        CL_QNAN  = 3'd4,
        CL_SNAN  = 3'd5
    } fp_class_e;

    // Rounding-mode encoding seen on the rnd_mode port
    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/fpsub_classify.sv
// Operand classifier.
// Splits one packed operand into sign, effective exponent and significand,
// and reports its class. A subnormal gets effective exponent 1 and no hidden
// bit, so the arithmetic path can treat it like a normal value.
module fpsub_classify
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [W-1:0]     operand,
    output fp_class_e        cls,
    output logic             sign,
    output logic [EXP_W-1:0] eff_exp,
    output logic [SIG_W-1:0] sig
);

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;
    logic              exp_zero;
    logic              exp_ones;

    // Field extraction and class decision
    always_comb begin
        sign       = operand[W-1];
        exp_field  = operand[W-2:FRAC_W];
        frac_field = operand[FRAC_W-1:0];
        exp_zero   = (exp_field == '0);
        exp_ones   = (exp_field == '1);
        eff_exp    = exp_zero ? EXP_W'(1) : exp_field;
        sig        = {~exp_zero, frac_field};
        if (exp_ones) begin
            if (frac_field == '0)          cls = CL_INF;
            else if (frac_field[FRAC_W-1]) cls = CL_QNAN;
            else                           cls = CL_SNAN;
        end else if (exp_zero) begin
            cls = (frac_field == '0) ? CL_ZERO : CL_SUB;
        end else begin
            cls = CL_NORM;
        end
    end

endmodule

// File: rtl/fpsub_special.sv
// Special-operand resolver.
// Applies the fixed priority over class pairs (signaling NaN, quiet NaN,
// infinity, zero) and says whether the arithmetic path is bypassed.
// Assumes the classes come from fpsub_classify on the same operands.
module fpsub_special
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val_x,
    input  logic [W-1:0] val_y,
    input  fp_class_e    cls_x,
    input  fp_class_e    cls_y,
    input  logic [1:0]   rnd_mode,
    output logic         bypass,
    output logic [W-1:0] bypass_val,
    output logic         bypass_invalid
);

    localparam logic [W-1:0] QUIET_BIT   = W'(1) << (FRAC_W - 1);
    localparam logic [W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic sx, sy;
    logic x_zero, y_zero;

    // Priority decision over the class pair
    always_comb begin
        sx             = val_x[W-1];
        sy             = val_y[W-1];
        x_zero         = (cls_x == CL_ZERO);
        y_zero         = (cls_y == CL_ZERO);
        bypass         = 1'b1;
        bypass_val     = val_x;
        bypass_invalid = 1'b0;
        if (cls_x == CL_SNAN) begin
            bypass_val     = val_x | QUIET_BIT;
            bypass_invalid = 1'b1;
        end else if (cls_y == CL_SNAN) begin
            bypass_val     = val_y | QUIET_BIT;
            bypass_invalid = 1'b1;
        end else if (cls_x == CL_QNAN) begin
            bypass_val = val_x;
        end else if (cls_y == CL_QNAN) begin
            bypass_val = val_y;
        end else if (cls_x == CL_INF && cls_y == CL_INF) begin
            if (sx == sy) begin
                bypass_val     = DEFAULT_NAN;
                bypass_invalid = 1'b1;
            end else begin
                bypass_val = val_x;
            end
        end else if (cls_y == CL_INF) begin
            bypass_val = {~sy, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cls_x == CL_INF) begin
            bypass_val = val_x;
        end else if (x_zero && y_zero) begin
            if (sx != sy) bypass_val = val_x;
            else          bypass_val = {(rnd_mode == RM_DOWN), {(W-1){1'b0}}};
        end else if (x_zero) begin
            bypass_val = {~sy, val_y[W-2:0]};
        end else if (y_zero) begin
            bypass_val = val_x;
        end else begin
            bypass = 1'b0;
        end
    end

endmodule

// File: rtl/fpsub_core.sv
// Arithmetic path for finite nonzero operands.
// Inverts the sign of y, aligns with a sticky right shift, adds or
// subtracts magnitudes, normalizes, rounds and packs the result.
// Assumes both effective exponents are at least 1 (subnormals arrive with
// exponent 1 and no hidden bit).
module fpsub_core
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int EXT_W = SIG_W + 3,
    localparam int SUM_W = EXT_W + 1,
    localparam int EI_W  = EXP_W + 2,
    localparam int LZ_W  = $clog2(EXT_W + 1)
) (
    input  logic             x_sign,
    input  logic [EXP_W-1:0] x_exp,
    input  logic [SIG_W-1:0] x_sig,
    input  logic             y_sign,
    input  logic [EXP_W-1:0] y_exp,
    input  logic [SIG_W-1:0] y_sig,
    input  logic [1:0]       rnd_mode,
    output logic [W-1:0]     core_val,
    output logic             core_overflow,
    output logic             core_underflow,
    output logic             core_inexact
);

    localparam logic [EI_W-1:0] EXP_LIMIT = EI_W'((1 << EXP_W) - 1);

    // Right shift that folds every lost bit into bit 0
    function automatic logic [EXT_W-1:0] shr_sticky(input logic [EXT_W-1:0] v,
                                                    input logic [EXP_W-1:0] amt);
        logic [EXT_W-1:0] kept;
        logic [EXT_W-1:0] lost_mask;
        if (int'(amt) >= EXT_W) begin
            shr_sticky = {{(EXT_W-1){1'b0}}, |v};
        end else begin
            kept       = v >> amt;
            lost_mask  = ~({EXT_W{1'b1}} << amt);
            kept[0]    = kept[0] | (|(v & lost_mask));
            shr_sticky = kept;
        end
    endfunction

    // Leading-zero count over the extended significand
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] n;
        n = LZ_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (v[i]) n = LZ_W'(EXT_W - 1 - i);
        end
        lead_zeros = n;
    endfunction

    logic             y_eff, eff_sub, swap, res_sign;
    logic [EXP_W-1:0] big_exp, small_exp, exp_gap;
    logic [SIG_W-1:0] big_sig, small_sig;
    logic [EXT_W-1:0] big_ext, small_al, norm;
    logic [SUM_W-1:0] raw_sum;
    logic [EI_W-1:0]  work_exp, room, shamt;
    logic [LZ_W-1:0]  lz;
    logic             guard, rest, inexact, tiny, round_up, to_inf, ovf;
    logic [SIG_W:0]   rounded;
    logic [SIG_W-1:0] mant;
    logic [EXP_W-1:0] exp_field;

    // Operand ordering and alignment
    always_comb begin
        y_eff     = ~y_sign;
        eff_sub   = x_sign ^ y_eff;
        swap      = (y_exp > x_exp) || ((y_exp == x_exp) && (y_sig > x_sig));
        res_sign  = swap ? y_eff : x_sign;
        big_exp   = swap ? y_exp : x_exp;
        big_sig   = swap ? y_sig : x_sig;
        small_exp = swap ? x_exp : y_exp;
        small_sig = swap ? x_sig : y_sig;
        exp_gap   = big_exp - small_exp;
        big_ext   = {big_sig, 3'b000};
        small_al  = shr_sticky({small_sig, 3'b000}, exp_gap);
        raw_sum   = eff_sub ? ({1'b0, big_ext} - {1'b0, small_al})
                            : ({1'b0, big_ext} + {1'b0, small_al});
    end

    // Normalization: carry right shift, or left shift bounded by exponent 1
    always_comb begin
        work_exp = {2'b00, big_exp};
        lz       = lead_zeros(raw_sum[EXT_W-1:0]);
        room     = work_exp - EI_W'(1);
        shamt    = '0;
        if (raw_sum[SUM_W-1]) begin
            norm     = {raw_sum[SUM_W-1:2], |raw_sum[1:0]};
            work_exp = work_exp + EI_W'(1);
        end else begin
            shamt    = (EI_W'(lz) > room) ? room : EI_W'(lz);
            norm     = raw_sum[EXT_W-1:0] << shamt;
            work_exp = work_exp - shamt;
        end
    end

    // Rounding and packing
    always_comb begin
        guard   = norm[2];
        rest    = |norm[1:0];
        inexact = guard | rest;
        tiny    = ~norm[EXT_W-1];
        unique case (rnd_mode)
            RM_NEAREST: round_up = guard & (rest | norm[3]);
            RM_ZERO:    round_up = 1'b0;
            RM_UP:      round_up = ~res_sign & inexact;
            default:    round_up = res_sign & inexact;
        endcase
        rounded = {1'b0, norm[EXT_W-1:3]} + (SIG_W+1)'(round_up);
        if (rounded[SIG_W]) begin
            mant = rounded[SIG_W:1];
            ovf  = (work_exp + EI_W'(1)) >= EXP_LIMIT;
            exp_field = EXP_W'(work_exp + EI_W'(1));
        end else begin
            mant = rounded[SIG_W-1:0];
            ovf  = work_exp >= EXP_LIMIT;
            exp_field = mant[SIG_W-1] ? work_exp[EXP_W-1:0] : '0;
        end
        to_inf = (rnd_mode == RM_NEAREST) || ((rnd_mode == RM_UP) && !res_sign)
               || ((rnd_mode == RM_DOWN) && res_sign);
        core_overflow  = 1'b0;
        core_underflow = 1'b0;
        core_inexact   = 1'b0;
        if (raw_sum == '0) begin
            core_val = {(rnd_mode == RM_DOWN), {(W-1){1'b0}}};
        end else if (ovf) begin
            core_overflow = 1'b1;
            core_inexact  = 1'b1;
            core_val = to_inf ? {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                              : {res_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else begin
            core_inexact   = inexact;
            core_underflow = tiny & inexact;
            core_val       = {res_sign, exp_field, mant[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fp32_subtractor.sv
// Top of the single-precision subtractor: classifies both operands,
// chooses between the special-case resolver and the arithmetic path,
// and registers the difference and flags one cycle after the strobe.
// Assumes rst_n is synchronous and active low.
module fp32_subtractor
    import fpsub_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [1:0]   rnd_mode,
    output logic         res_valid,
    output logic [W-1:0] diff_out,
    output logic         flag_invalid,
    output logic         flag_overflow,
    output logic         flag_underflow,
    output logic         flag_inexact
);

    logic [1:0][W-1:0]     ops;
    fp_class_e             cls     [2];
    logic [1:0]            signs;
    logic [1:0][EXP_W-1:0] exps;
    logic [1:0][SIG_W-1:0] sigs;

    assign ops[0] = op_x;
    assign ops[1] = op_y;

    // One classifier per operand
    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpsub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand (ops[g]),
            .cls     (cls[g]),
            .sign    (signs[g]),
            .eff_exp (exps[g]),
            .sig     (sigs[g])
        );
    end

    logic         sp_bypass, sp_invalid;
    logic [W-1:0] sp_val;

    fpsub_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
        .val_x          (op_x),
        .val_y          (op_y),
        .cls_x          (cls[0]),
        .cls_y          (cls[1]),
        .rnd_mode       (rnd_mode),
        .bypass         (sp_bypass),
        .bypass_val     (sp_val),
        .bypass_invalid (sp_invalid)
    );

    logic [W-1:0] ar_val;
    logic         ar_ovf, ar_unf, ar_inx;

    fpsub_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .x_sign         (signs[0]),
        .x_exp          (exps[0]),
        .x_sig          (sigs[0]),
        .y_sign         (signs[1]),
        .y_exp          (exps[1]),
        .y_sig          (sigs[1]),
        .rnd_mode       (rnd_mode),
        .core_val       (ar_val),
        .core_overflow  (ar_ovf),
        .core_underflow (ar_unf),
        .core_inexact   (ar_inx)
    );

    // Output register: capture on strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            diff_out       <= '0;
            flag_invalid   <= 1'b0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
            flag_inexact   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                diff_out       <= sp_bypass ? sp_val : ar_val;
                flag_invalid   <= sp_bypass & sp_invalid;
                flag_overflow  <= ~sp_bypass & ar_ovf;
                flag_underflow <= ~sp_bypass & ar_unf;
                flag_inexact   <= ~sp_bypass & ar_inx;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(diff_out))); // R1
    AST_SNAN_X_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_x[W-2:FRAC_W] == '1 && !op_x[FRAC_W-1] && op_x[FRAC_W-2:0] != '0)
        |=> (flag_invalid && diff_out == ($past(op_x) | (W'(1) << (FRAC_W-1))))); // R2
    AST_QNAN_X_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_x[W-2:FRAC_W] == '1 && op_x[FRAC_W-1]
         && !(op_y[W-2:FRAC_W] == '1 && !op_y[FRAC_W-1] && op_y[FRAC_W-2:0] != '0))
        |=> (!flag_invalid && diff_out == $past(op_x))); // R3
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> flag_inexact); // R9
    AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> flag_inexact); // R10

endmodule

// File: tb/fp32_subtractor_test.sv
// Directed bench for fp32_subtractor: one task per scenario.
module fp32_subtractor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_x = '0;
    logic [31:0] op_y = '0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        res_valid;
    logic [31:0] diff_out;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fp32_subtractor uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid       (op_valid),
        .op_x           (op_x),
        .op_y           (op_y),
        .rnd_mode       (rnd_mode),
        .res_valid      (res_valid),
        .diff_out       (diff_out),
        .flag_invalid   (flag_invalid),
        .flag_overflow  (flag_overflow),
        .flag_underflow (flag_underflow),
        .flag_inexact   (flag_inexact)
    );

    // flags packed as {invalid, overflow, underflow, inexact}
    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one operation and check the registered outcome a cycle later
    task automatic run_op(input string req, input logic [31:0] x, input logic [31:0] y,
                          input logic [1:0] rm, input logic [31:0] exp_val,
                          input logic [3:0] exp_flags);
        @(negedge clk);
        op_x = x; op_y = y; rnd_mode = rm; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check_val(req, "valid", {31'd0, res_valid}, 32'd1);
        check_val(req, "result", diff_out, exp_val);
        check_val(req, "flags",
                  {28'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact},
                  {28'd0, exp_flags});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1", "reset valid", {31'd0, res_valid}, 32'd0);
        check_val("R1", "reset result", diff_out, 32'd0);
        check_val("R1", "reset flags",
                  {28'd0, flag_invalid, flag_overflow, flag_underflow, flag_inexact}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_hold();
        run_op("R1", 32'h40400000, 32'h3F800000, 2'd0, 32'h40000000, 4'b0000);
        // change inputs without a strobe: nothing may move
        op_x = 32'h7F800001; op_y = 32'h3F800000;
        repeat (3) begin
            @(negedge clk);
            check_val("R1", "idle valid", {31'd0, res_valid}, 32'd0);
            check_val("R1", "idle hold", diff_out, 32'h40000000);
            check_val("R1", "idle flags", {31'd0, flag_invalid}, 32'd0);
        end
    endtask

    task automatic t_signaling();
        run_op("R2", 32'h7F800001, 32'h3F800000, 2'd0, 32'h7FC00001, 4'b1000);
        run_op("R2", 32'h3F800000, 32'hFF800005, 2'd0, 32'hFFC00005, 4'b1000);
        run_op("R2", 32'h7F800002, 32'h7FC00000, 2'd0, 32'h7FC00002, 4'b1000);
        run_op("R2", 32'h7FC00000, 32'h7F800003, 2'd0, 32'h7FC00003, 4'b1000);
    endtask

    task automatic t_quiet();
        run_op("R3", 32'h3F800000, 32'h7FC12345, 2'd0, 32'h7FC12345, 4'b0000);
        run_op("R3", 32'hFFC00001, 32'h7FC00002, 2'd0, 32'hFFC00001, 4'b0000);
        run_op("R3", 32'h7FC00400, 32'h7F800000, 2'd1, 32'h7FC00400, 4'b0000);
    endtask

    task automatic t_inf_pair();
        run_op("R4", 32'h7F800000, 32'h7F800000, 2'd0, 32'h7FC00000, 4'b1000);
        run_op("R4", 32'h7F800000, 32'hFF800000, 2'd0, 32'h7F800000, 4'b0000);
    endtask

    task automatic t_inf_mixed();
        run_op("R5", 32'h3F800000, 32'h7F800000, 2'd0, 32'hFF800000, 4'b0000);
        run_op("R5", 32'h00000000, 32'hFF800000, 2'd0, 32'h7F800000, 4'b0000);
        run_op("R5", 32'hFF800000, 32'h3F800000, 2'd0, 32'hFF800000, 4'b0000);
    endtask

    task automatic t_zeros();
        run_op("R6", 32'h00000000, 32'h00000000, 2'd0, 32'h00000000, 4'b0000);
        run_op("R6", 32'h00000000, 32'h00000000, 2'd3, 32'h80000000, 4'b0000);
        run_op("R6", 32'h80000000, 32'h80000000, 2'd2, 32'h00000000, 4'b0000);
        run_op("R6", 32'h00000000, 32'h80000000, 2'd3, 32'h00000000, 4'b0000);
        run_op("R6", 32'h80000000, 32'h00000000, 2'd0, 32'h80000000, 4'b0000);
        run_op("R6", 32'h00000000, 32'h3FC00000, 2'd0, 32'hBFC00000, 4'b0000);
        run_op("R6", 32'h40200000, 32'h80000000, 2'd0, 32'h40200000, 4'b0000);
        run_op("R6", 32'h00000000, 32'h00000005, 2'd0, 32'h80000005, 4'b0000);
    endtask

    task automatic t_general();
        run_op("R7", 32'h3F800000, 32'hBF800000, 2'd0, 32'h40000000, 4'b0000);
        run_op("R7", 32'h3F800000, 32'h40400000, 2'd0, 32'hC0000000, 4'b0000);
        run_op("R7", 32'h3F800000, 32'h33800000, 2'd1, 32'h3F7FFFFF, 4'b0000);
        // 1 + 2^-24: a tie in every mode
        run_op("R7", 32'h3F800000, 32'hB3800000, 2'd0, 32'h3F800000, 4'b0001);
        run_op("R7", 32'h3F800000, 32'hB3800000, 2'd1, 32'h3F800000, 4'b0001);
        run_op("R7", 32'h3F800000, 32'hB3800000, 2'd2, 32'h3F800001, 4'b0001);
        run_op("R7", 32'h3F800000, 32'hB3800000, 2'd3, 32'h3F800000, 4'b0001);
        run_op("R7", 32'hBF800000, 32'h33800000, 2'd3, 32'hBF800001, 4'b0001);
        run_op("R7", 32'hBF800000, 32'h33800000, 2'd2, 32'hBF800000, 4'b0001);
        // tie with odd last bit rounds up to even
        run_op("R7", 32'h3F800001, 32'hB3800000, 2'd0, 32'h3F800002, 4'b0001);
    endtask

    task automatic t_exact_zero();
        run_op("R8", 32'h3F800000, 32'h3F800000, 2'd0, 32'h00000000, 4'b0000);
        run_op("R8", 32'h3F800000, 32'h3F800000, 2'd3, 32'h80000000, 4'b0000);
        run_op("R8", 32'hC0A00000, 32'hC0A00000, 2'd2, 32'h00000000, 4'b0000);
    endtask

    task automatic t_overflow();
        run_op("R9", 32'h7F7FFFFF, 32'hFF7FFFFF, 2'd0, 32'h7F800000, 4'b0101);
        run_op("R9", 32'h7F7FFFFF, 32'hFF7FFFFF, 2'd1, 32'h7F7FFFFF, 4'b0101);
        run_op("R9", 32'hFF7FFFFF, 32'h7F7FFFFF, 2'd2, 32'hFF7FFFFF, 4'b0101);
        run_op("R9", 32'hFF7FFFFF, 32'h7F7FFFFF, 2'd3, 32'hFF800000, 4'b0101);
    endtask

    task automatic t_subnormal();
        run_op("R10", 32'h00000003, 32'h00000001, 2'd0, 32'h00000002, 4'b0000);
        run_op("R10", 32'h00800000, 32'h00000001, 2'd0, 32'h007FFFFF, 4'b0000);
        run_op("R10", 32'h00400000, 32'h80400000, 2'd0, 32'h00800000, 4'b0000);
        run_op("R10", 32'h3F800000, 32'h00000001, 2'd1, 32'h3F7FFFFF, 4'b0001);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_hold();
        t_signaling();
        t_quiet();
        t_inf_pair();
        t_inf_mixed();
        t_zeros();
        t_general();
        t_exact_zero();
        t_overflow();
        t_subnormal();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule